// File: doc/BRIEF.md
# Folded Walsh-Hadamard Transform Engine

This block computes an N-point Walsh-Hadamard transform (N = 2^LOG_N) of signed two's-complement samples. The whole input vector arrives at once, qualified by a valid strobe. The block returns the transform in natural (Sylvester) order, also all at once, together with a one-cycle done strobe. Every stage of the transform has the same shape: a perfect-shuffle reordering of the lanes, then add/subtract butterflies on neighbouring lane pairs. Because of this, the block builds only LOG_N/FOLD such stages in hardware and runs the data around them FOLD times.

The parameter FOLD is the horizontal folding degree and must divide LOG_N. A larger FOLD means fewer adders and more recirculation cycles, which lowers throughput. Each stage adds one bit of word growth, so every output lane is LOG_N bits wider than an input lane and never overflows. While passes are running the engine deasserts its ready output and takes no new work.

Top module: `wht_fold_engine`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and out_data is all zeros.
- R2: A vector is accepted on a clock edge where in_valid and in_ready are both 1. For the next FOLD cycles in_ready is 0, and in_valid together with in_data is ignored during those cycles: it neither changes the result nor starts another transform.
- R3: out_valid is high for exactly one cycle. It rises FOLD clock edges after the accepting edge.
- R4: Output lane k, at out_data[k*OUT_W +: OUT_W], equals the sum over i of (-1)^popcount(i AND k) times input lane i. Input lane i is the two's-complement value at in_data[i*IN_W +: IN_W].
- R5: OUT_W = IN_W + LOG_N, and no input pattern overflows. With the defaults, all lanes at -128 give -8192 in lane 0, and all lanes at 127 give 8128 in lane 0. Every other lane is 0 in both cases.
- R6: out_data holds its value in every cycle in which out_valid is 0.
- R7: in_ready is 1 in the cycle in which out_valid is 1. A vector offered in that cycle is accepted, so transforms can run back to back.
- R8: An impulse of value a in input lane j gives (-1)^popcount(j AND k) times a in every output lane k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input vector is valid |
| in_ready | output | 1 | Engine is idle and can accept a vector |
| in_data | input | N*IN_W | Input lanes, lane i at bits [i*IN_W +: IN_W] |
| out_valid | output | 1 | One-cycle strobe: a new result is in out_data |
| out_data | output | N*OUT_W | Output lanes, lane k at bits [k*OUT_W +: OUT_W] |

## Verification
Impulses in lanes 0, 1, 37 and 63 each select a single column of the Hadamard matrix. A wrong shuffle direction or an output lane order that is not natural shows up as sign errors in exactly those lanes. Uniform vectors at the most negative and the most positive input value push word growth to its limit and find any missing bit of sign extension. An alternating pattern and random vectors cover the general mixing of all the passes. Further directed sequences check that an offer made while the engine is busy is ignored, that the result holds while no strobe is present, and that the engine accepts new work in the same cycle as its done strobe.

// File: rtl/wht_pkg.sv
`timescale 1ns/1ps
package wht_pkg;

  // Source lane feeding destination lane `dst` under the perfect shuffle.
  // Lane i moves to (i mod 2)*lanes/2 + i/2.
  function automatic int shuf_src(input int dst, input int lanes);
    if (dst < lanes / 2) return 2 * dst;
    else                 return 2 * (dst - lanes / 2) + 1;
  endfunction

endpackage

// File: rtl/wht_stage.sv
`timescale 1ns/1ps
module wht_stage #(
  parameter int LANES = 8,
  parameter int W     = 11
) (
  input  logic [LANES*W-1:0] d,
  output logic [LANES*W-1:0] q
);
  localparam int PAIRS = LANES / 2;

  for (genvar p = 0; p < PAIRS; p++) begin : g_bfly
    localparam int SRC_A = wht_pkg::shuf_src(2 * p, LANES);
    localparam int SRC_B = wht_pkg::shuf_src(2 * p + 1, LANES);
    logic signed [W-1:0] a, b;
    assign a = d[SRC_A*W +: W];
    assign b = d[SRC_B*W +: W];
    assign q[(2*p)*W +: W]   = a + b;
    assign q[(2*p+1)*W +: W] = a - b;
  end
endmodule

// File: rtl/wht_chain.sv
`timescale 1ns/1ps
module wht_chain #(
  parameter int LANES = 8,
  parameter int W     = 11,
  parameter int DEPTH = 1
) (
  input  logic [LANES*W-1:0] d,
  output logic [LANES*W-1:0] q
);
  logic [LANES*W-1:0] link [DEPTH+1];

  assign link[0] = d;
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    wht_stage #(.LANES(LANES), .W(W)) u_stage (
      .d(link[s]),
      .q(link[s+1])
    );
  end
  assign q = link[DEPTH];
endmodule

// File: rtl/wht_pass_ctrl.sv
`timescale 1ns/1ps
module wht_pass_ctrl #(
  parameter int FOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic last
);
  localparam int CW = (FOLD > 1) ? $clog2(FOLD) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(FOLD - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign in_ready = !busy_q;
  assign load     = in_valid && !busy_q;
  assign step     = busy_q;
  assign last     = busy_q && (cnt_q == LAST_CNT);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/wht_fold_engine.sv
`timescale 1ns/1ps
module wht_fold_engine #(
  parameter int LOG_N = 6,
  parameter int IN_W  = 8,
  parameter int FOLD  = 6,
  localparam int N     = 1 << LOG_N,
  localparam int OUT_W = IN_W + LOG_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [N*IN_W-1:0]  in_data,
  output logic               out_valid,
  output logic [N*OUT_W-1:0] out_data
);
  localparam int DEPTH = LOG_N / FOLD;

  logic               load, step, last;
  logic [N*OUT_W-1:0] work_q, work_d, chain_q, ext_in, res_q;
  logic               work_en;
  logic               vld_q;

  wht_pass_ctrl #(.FOLD(FOLD)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .load    (load),
    .step    (step),
    .last    (last)
  );

  for (genvar i = 0; i < N; i++) begin : g_ext
    assign ext_in[i*OUT_W +: OUT_W] =
      {{LOG_N{in_data[i*IN_W + IN_W - 1]}}, in_data[i*IN_W +: IN_W]};
  end

  wht_chain #(.LANES(N), .W(OUT_W), .DEPTH(DEPTH)) u_chain (
    .d(work_q),
    .q(chain_q)
  );

  assign work_en = load || step;

  always_comb begin
    work_d = chain_q;
    if (load) work_d = ext_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (last) begin
      res_q <= chain_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= last;
  end

  assign out_valid = vld_q;
  assign out_data  = res_q;
endmodule

// File: rtl/wht_fold_engine_chk.sv
`timescale 1ns/1ps
module wht_fold_engine_chk #(
  parameter int FOLD = 6,
  parameter int DW   = 896
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  logic [15:0] since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_acc <= 16'hFFFF;
    else if (in_valid && in_ready)  since_acc <= 16'd0;
    else if (since_acc != 16'hFFFF) since_acc <= since_acc + 16'd1;
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_acc == 16'(FOLD)));

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));

  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  p_ready_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

bind wht_fold_engine wht_fold_engine_chk #(.FOLD(FOLD), .DW(N*OUT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/sim_wht_fold_engine.sv
`timescale 1ns/1ps
module sim_wht_fold_engine;
  localparam int LOG_N = 6;
  localparam int IN_W  = 8;
  localparam int FOLD  = 6;
  localparam int N     = 1 << LOG_N;
  localparam int OUT_W = IN_W + LOG_N;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic               in_ready;
  logic [N*IN_W-1:0]  in_data;
  logic               out_valid;
  logic [N*OUT_W-1:0] out_data;

  int checks = 0;
  int failures = 0;

  logic signed [IN_W-1:0] cur [N];

  always #4 clk = ~clk;

  wht_fold_engine #(.LOG_N(LOG_N), .IN_W(IN_W), .FOLD(FOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic signed [OUT_W-1:0] ref_lane(input int k);
    int s = 0;
    for (int i = 0; i < N; i++) begin
      if ($countones(i & k) % 2 == 1) s = s - int'(cur[i]);
      else                            s = s + int'(cur[i]);
    end
    return s[OUT_W-1:0];
  endfunction

  function automatic logic [N*IN_W-1:0] pack_cur();
    logic [N*IN_W-1:0] v;
    for (int i = 0; i < N; i++) v[i*IN_W +: IN_W] = cur[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_result(input string req);
    int bad = 0;
    int first = -1;
    for (int k = 0; k < N; k++) begin
      if ($signed(out_data[k*OUT_W +: OUT_W]) != ref_lane(k)) begin
        bad++;
        if (first < 0) first = k;
      end
    end
    if (first < 0) check(1'b1, req, "lanes", 0, 0);
    else check(1'b0, req, $sformatf("lane %0d", first),
               longint'($signed(out_data[first*OUT_W +: OUT_W])),
               longint'(ref_lane(first)));
  endtask

  // Called at a negedge with in_ready high; returns at the negedge where out_valid is 1.
  task automatic run_vec(input string req, input bit inject);
    int lat;
    in_data  = pack_cur();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2", "ready after accept", in_ready, 0);
    if (inject) begin
      in_valid = 1'b1;
      in_data  = ~pack_cur();
    end
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      in_valid = 1'b0;
      if (out_valid) break;
      if (lat > FOLD + 4) break;
    end
    check(out_valid == 1'b1 && lat == FOLD, "R3", "latency", lat, FOLD);
    check(in_ready == 1'b1, "R7", "ready at done", in_ready, 1);
    check_result(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    check(out_data == '0, "R1", "out_data zero", out_data == '0, 1);

    // R8: impulses
    foreach (cur[i]) cur[i] = '0;
    cur[0] = 8'sd100;            run_vec("R8", 1'b0); @(negedge clk);
    cur[0] = '0; cur[1] = -8'sd128; run_vec("R8", 1'b0); @(negedge clk);
    cur[1] = '0; cur[37] = 8'sd77;  run_vec("R8", 1'b0); @(negedge clk);
    cur[37] = '0; cur[63] = -8'sd5; run_vec("R8", 1'b0); @(negedge clk);

    // R5: extreme uniform vectors
    foreach (cur[i]) cur[i] = -8'sd128;
    run_vec("R5", 1'b0);
    check($signed(out_data[0 +: OUT_W]) == -8192, "R5", "lane0 min",
          $signed(out_data[0 +: OUT_W]), -8192);
    @(negedge clk);
    foreach (cur[i]) cur[i] = 8'sd127;
    run_vec("R5", 1'b0);
    check($signed(out_data[0 +: OUT_W]) == 8128, "R5", "lane0 max",
          $signed(out_data[0 +: OUT_W]), 8128);
    @(negedge clk);

    // R4: alternating pattern
    foreach (cur[i]) cur[i] = (i % 2 == 0) ? 8'sd90 : -8'sd90;
    run_vec("R4", 1'b0); @(negedge clk);

    // R2: offer during busy is ignored (result and no extra strobe)
    foreach (cur[i]) cur[i] = IN_W'($urandom);
    run_vec("R2", 1'b1);
    begin
      logic [N*OUT_W-1:0] held;
      bit extra;
      held  = out_data;
      extra = 1'b0;
      for (int c = 0; c < FOLD + 3; c++) begin
        @(negedge clk);
        if (out_valid) extra = 1'b1;
      end
      check(!extra, "R2", "no strobe from ignored offer", extra, 0);
      // R6: result held without strobe
      check(out_data == held, "R6", "out_data held", out_data == held, 1);
    end

    // R4 random plus R7 back-to-back
    for (int v = 0; v < 20; v++) begin
      foreach (cur[i]) cur[i] = IN_W'($urandom);
      run_vec((v % 2 == 1) ? "R7" : "R4", 1'b0);
      if (v % 2 == 0) @(negedge clk);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule